// File: doc/BRIEF.md
# Quad-Port Event Interrupt Aggregator

This block gathers event indications from four line ports and folds them into one active-low interrupt pin. Each port owns two 8-bit status registers, so the block latches 64 event sources in all. Each status register has its own 8-bit enable mask. A bit position is set at build time to be either a level source or an edge source. A level source keeps setting its status bit for as long as the event input is high. An edge source sets its bit once, on the cycle the event is first seen. It can set the bit again only after the event has gone low and then come back.

A host reaches the block through a small register port. The port carries a port select, an 8-bit address, separate read and write strobes, write data and registered read data. Reading a status register returns its contents and clears it in the same cycle. A packed summary word shows which of the eight status registers currently has an unmasked bit set. The summary can be read from any port select at any of three otherwise unused addresses, so an interrupt handler finds the source in one access. The circuits that detect the events are outside this block.

Top module: `quad_evt_irq_agg`

## Requirements
- R1: After synchronous reset every status bit and every mask bit is 0, int_n_o is 1 and host_rdata_o is 0.
- R2: A level-kind source (bit positions where ONESHOT_BITS is 0; default bits 3:0) sets its status bit on every clock edge at which its event input is 1. A read that coincides with such an edge leaves the bit at 1. Once the event is low, one read returns the bit and clears it.
- R3: An edge-kind source (bit positions where ONESHOT_BITS is 1; default bits 7:4) sets its status bit only at the first edge where its event is 1 after being 0. If the event is held high, clearing the bit by a read does not set it again. After the event drops and rises again, the bit is set again.
- R4: Status register r (r = 0 or 1) of the selected port is read at address 0x10 + r. The read returns the value held before the edge and clears only that register of that port.
- R5: The mask of status register r of the selected port is written and read back at address 0x18 + r. A masked-off bit still latches in status but does not make the register pending.
- R6: A read at address 0x0C, 0x0D or 0x0E with any port select returns the summary word. Bit 2*p + r is 1 when status register r of port p (p = 0..3) has a bit set whose mask bit is also set.
- R7: int_n_o is 0 exactly when at least one summary bit was 1 at the previous clock edge. It is registered, so it follows a change in pending state by one cycle.
- R8: Writes to status or summary addresses change nothing, and a read at any unmapped address returns 0.
- R9: The kind of each bit position is chosen by the ONESHOT_BITS parameter. The same pattern applies to every status register. With level and edge sources held high together, the level bits survive a read and the edge bits do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_i | input | 64 | Event inputs; bit (2*p + r)*8 + b is bit b of status register r of port p |
| host_sel_i | input | 2 | Port select for host accesses |
| host_addr_i | input | 8 | Host register address |
| host_wr_i | input | 1 | Host write strobe, one cycle per write |
| host_wdata_i | input | 8 | Host write data |
| host_rd_i | input | 1 | Host read strobe, one cycle per read; clears an addressed status register |
| host_rdata_o | output | 8 | Read data, registered, valid the cycle after the read strobe |
| int_n_o | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach is an edge-kind source held high across a clearing read, because its status must then stay 0 even though its event input is still asserted. The bench holds such an event high and reads the register twice. It expects the bit on the first read and 0 on the second. It then drops the event and raises it again to show that the source re-arms. Read isolation is driven with one-cycle pulses into two registers of one port. The bench then reads another port, the first register twice, and then the second register. This shows that each read clears only what it addresses. The one-cycle latency of the interrupt pin is sampled on both sides of a mask write and of a clearing read.

// File: rtl/iagg_pkg.sv
package iagg_pkg;

  // Each port carries two status registers.
  localparam int REGS_PER_PORT = 2;

  // Host address map.
  localparam logic [7:0] ADDR_STAT_BASE = 8'h10;
  localparam logic [7:0] ADDR_MASK_BASE = 8'h18;
  localparam logic [7:0] ADDR_SUM_0     = 8'h0C;
  localparam logic [7:0] ADDR_SUM_1     = 8'h0D;
  localparam logic [7:0] ADDR_SUM_2     = 8'h0E;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_STAT = 2'd1,
    ACC_MASK = 2'd2,
    ACC_SUM  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [0:0] reg_idx;
  } acc_dec_t;

  function automatic acc_dec_t decode_addr(input logic [7:0] a);
    acc_dec_t d;
    d.kind    = ACC_NONE;
    d.reg_idx = 1'b0;
    if (a == ADDR_SUM_0 || a == ADDR_SUM_1 || a == ADDR_SUM_2) begin
      d.kind = ACC_SUM;
    end else if (a[7:1] == ADDR_STAT_BASE[7:1]) begin
      d.kind    = ACC_STAT;
      d.reg_idx = a[0];
    end else if (a[7:1] == ADDR_MASK_BASE[7:1]) begin
      d.kind    = ACC_MASK;
      d.reg_idx = a[0];
    end
    return d;
  endfunction

endpackage

// File: rtl/iagg_src_bank.sv
// One status register: per-bit source kind, latch with set-over-clear,
// enable mask and pending flag.
module iagg_src_bank #(
  parameter int SW = 8,
  parameter logic [SW-1:0] ONESHOT_BITS = 8'hF0
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [SW-1:0] evt_i,
  input  logic          rd_clr_i,
  input  logic          mask_we_i,
  input  logic [SW-1:0] mask_wdata_i,
  output logic [SW-1:0] status_o,
  output logic [SW-1:0] mask_o,
  output logic          pend_o
);

  logic [SW-1:0] prev_q;
  logic [SW-1:0] stat_q;
  logic [SW-1:0] mask_q;
  logic [SW-1:0] set_v;

  // Per-bit choice of source kind.
  for (genvar b = 0; b < SW; b++) begin : g_kind
    if (ONESHOT_BITS[b]) begin : g_edge
      assign set_v[b] = evt_i[b] & ~prev_q[b];
    end else begin : g_level
      assign set_v[b] = evt_i[b];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      prev_q <= evt_i;
      // A new set wins over a clearing read at the same edge.
      stat_q <= (rd_clr_i ? '0 : stat_q) | set_v;
      if (mask_we_i) begin
        mask_q <= mask_wdata_i;
      end
    end
  end

  assign status_o = stat_q;
  assign mask_o   = mask_q;
  assign pend_o   = |(stat_q & mask_q);

endmodule

// File: rtl/iagg_host_dec.sv
// Turns a host access into per-register clear and mask-write strobes.
module iagg_host_dec #(
  parameter int NP    = 4,
  parameter int SEL_W = 2,
  localparam int NREG = NP * iagg_pkg::REGS_PER_PORT
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [7:0]       addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  output logic [NREG-1:0]  rd_clr_o,
  output logic [NREG-1:0]  mask_we_o
);
  import iagg_pkg::*;

  acc_dec_t dec;
  assign dec = decode_addr(addr_i);

  for (genvar p = 0; p < NP; p++) begin : g_port
    for (genvar r = 0; r < REGS_PER_PORT; r++) begin : g_reg
      localparam int U = p * REGS_PER_PORT + r;
      logic hit;
      assign hit = (sel_i == SEL_W'(p)) && (dec.reg_idx == 1'(r));
      assign rd_clr_o[U]  = rd_i && hit && (dec.kind == ACC_STAT);
      assign mask_we_o[U] = wr_i && hit && (dec.kind == ACC_MASK);
    end
  end

endmodule

// File: rtl/iagg_rd_mux.sv
// Selects the read word and registers it.
module iagg_rd_mux #(
  parameter int NP    = 4,
  parameter int SW    = 8,
  parameter int SEL_W = 2,
  localparam int NREG  = NP * iagg_pkg::REGS_PER_PORT,
  localparam int IDX_W = SEL_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     rd_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [7:0]               addr_i,
  input  logic [NREG-1:0][SW-1:0]  stat_i,
  input  logic [NREG-1:0][SW-1:0]  mask_i,
  input  logic [NREG-1:0]          pend_i,
  output logic [SW-1:0]            rdata_o
);
  import iagg_pkg::*;

  acc_dec_t         dec;
  logic [IDX_W-1:0] idx;
  logic [SW-1:0]    sum_word;
  logic [SW-1:0]    rd_word;
  logic [SW-1:0]    rdata_q;

  always_comb begin
    sum_word = '0;
    for (int i = 0; i < NREG && i < SW; i++) begin
      sum_word[i] = pend_i[i];
    end
  end

  always_comb begin
    dec     = decode_addr(addr_i);
    idx     = {sel_i, dec.reg_idx};
    rd_word = '0;
    unique case (dec.kind)
      ACC_STAT: if (int'(idx) < NREG) rd_word = stat_i[idx];
      ACC_MASK: if (int'(idx) < NREG) rd_word = mask_i[idx];
      ACC_SUM:  rd_word = sum_word;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rd_word;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/quad_evt_irq_agg.sv
module quad_evt_irq_agg #(
  parameter int NP = 4,
  parameter int SW = 8,
  parameter logic [SW-1:0] ONESHOT_BITS = 8'hF0,
  localparam int NREG  = NP * iagg_pkg::REGS_PER_PORT,
  localparam int SEL_W = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NREG*SW-1:0] evt_i,
  input  logic [SEL_W-1:0]   host_sel_i,
  input  logic [7:0]         host_addr_i,
  input  logic               host_wr_i,
  input  logic [SW-1:0]      host_wdata_i,
  input  logic               host_rd_i,
  output logic [SW-1:0]      host_rdata_o,
  output logic               int_n_o
);

  logic [NREG-1:0]          rd_clr;
  logic [NREG-1:0]          mask_we;
  logic [NREG-1:0][SW-1:0]  stat_arr;
  logic [NREG-1:0][SW-1:0]  mask_arr;
  logic [NREG-1:0]          pend_vec;
  logic [NREG*SW-1:0]       status_flat;
  logic                     int_n_q;

  iagg_host_dec #(.NP(NP), .SEL_W(SEL_W)) u_dec (
    .sel_i     (host_sel_i),
    .addr_i    (host_addr_i),
    .rd_i      (host_rd_i),
    .wr_i      (host_wr_i),
    .rd_clr_o  (rd_clr),
    .mask_we_o (mask_we)
  );

  for (genvar u = 0; u < NREG; u++) begin : g_bank
    iagg_src_bank #(.SW(SW), .ONESHOT_BITS(ONESHOT_BITS)) u_bank (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .evt_i        (evt_i[u*SW +: SW]),
      .rd_clr_i     (rd_clr[u]),
      .mask_we_i    (mask_we[u]),
      .mask_wdata_i (host_wdata_i),
      .status_o     (stat_arr[u]),
      .mask_o       (mask_arr[u]),
      .pend_o       (pend_vec[u])
    );
    assign status_flat[u*SW +: SW] = stat_arr[u];
  end

  iagg_rd_mux #(.NP(NP), .SW(SW), .SEL_W(SEL_W)) u_mux (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .rd_i    (host_rd_i),
    .sel_i   (host_sel_i),
    .addr_i  (host_addr_i),
    .stat_i  (stat_arr),
    .mask_i  (mask_arr),
    .pend_i  (pend_vec),
    .rdata_o (host_rdata_o)
  );

  // Registered active-low interrupt.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      int_n_q <= 1'b1;
    end else begin
      int_n_q <= ~|pend_vec;
    end
  end

  assign int_n_o = int_n_q;

endmodule

// File: rtl/iagg_checker.sv
module iagg_checker #(
  parameter int NP = 4,
  parameter int SW = 8,
  parameter logic [SW-1:0] ONESHOT_BITS = 8'hF0,
  localparam int NREG  = NP * iagg_pkg::REGS_PER_PORT,
  localparam int SEL_W = (NP > 1) ? $clog2(NP) : 1
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic [NREG*SW-1:0] evt_i,
  input logic [SEL_W-1:0]   host_sel_i,
  input logic [7:0]         host_addr_i,
  input logic               host_rd_i,
  input logic               int_n_o,
  input logic [NREG*SW-1:0] status_flat,
  input logic [NREG-1:0]    pend_vec
);
  import iagg_pkg::*;

  // R1: reset leaves the interrupt deasserted
  p_reset_idle_r1: assert property (@(posedge clk_i) rst_i |=> int_n_o);

  // R7: pending state drives the pin one cycle later
  p_int_low_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (|pend_vec) |=> !int_n_o);
  p_int_high_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (~|pend_vec) |=> int_n_o);

  for (genvar p = 0; p < NP; p++) begin : g_port
    for (genvar r = 0; r < REGS_PER_PORT; r++) begin : g_reg
      localparam int U = p * REGS_PER_PORT + r;
      logic rd_hit;
      assign rd_hit = host_rd_i && (host_sel_i == SEL_W'(p)) &&
                      (host_addr_i == (ADDR_STAT_BASE + 8'(r)));
      for (genvar b = 0; b < SW; b++) begin : g_bit
        localparam int I = U * SW + b;
        // R4: a read with no new event clears the bit
        p_read_clears_r4: assert property (@(posedge clk_i) disable iff (rst_i)
          (rd_hit && !evt_i[I]) |=> !status_flat[I]);
        if (ONESHOT_BITS[b]) begin : g_edge
          // R3: an edge source only sets on a 0-to-1 event change
          p_oneshot_edge_r3: assert property (@(posedge clk_i) disable iff (rst_i)
            ($rose(status_flat[I]) && !$past(rst_i, 2)) |->
              ($past(evt_i[I]) && !$past(evt_i[I], 2)));
        end else begin : g_level
          // R2: a level source holds its bit while active
          p_level_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
            evt_i[I] |=> status_flat[I]);
        end
      end
    end
  end

endmodule

bind quad_evt_irq_agg iagg_checker #(
  .NP(NP), .SW(SW), .ONESHOT_BITS(ONESHOT_BITS)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .evt_i       (evt_i),
  .host_sel_i  (host_sel_i),
  .host_addr_i (host_addr_i),
  .host_rd_i   (host_rd_i),
  .int_n_o     (int_n_o),
  .status_flat (status_flat),
  .pend_vec    (pend_vec)
);

// File: tb/tb_quad_evt_irq_agg.sv
module tb_quad_evt_irq_agg;

  logic        clk = 1'b0;
  logic        rst_i;
  logic [63:0] evt_i;
  logic [1:0]  host_sel_i;
  logic [7:0]  host_addr_i;
  logic        host_wr_i;
  logic [7:0]  host_wdata_i;
  logic        host_rd_i;
  logic [7:0]  host_rdata_o;
  logic        int_n_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  quad_evt_irq_agg dut (
    .clk_i        (clk),
    .rst_i        (rst_i),
    .evt_i        (evt_i),
    .host_sel_i   (host_sel_i),
    .host_addr_i  (host_addr_i),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .host_rd_i    (host_rd_i),
    .host_rdata_o (host_rdata_o),
    .int_n_o      (int_n_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int ev(input int p, input int r, input int b);
    return (p * 2 + r) * 8 + b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_read(input int p, input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel_i  = 2'(p);
    host_addr_i = a;
    host_rd_i   = 1'b1;
    @(negedge clk);
    host_rd_i = 1'b0;
    d = host_rdata_o;
  endtask

  task automatic host_write(input int p, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel_i   = 2'(p);
    host_addr_i  = a;
    host_wdata_i = d;
    host_wr_i    = 1'b1;
    @(negedge clk);
    host_wr_i = 1'b0;
  endtask

  task automatic set_evt(input int i, input logic v);
    @(negedge clk);
    evt_i[i] = v;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 int_n after reset", 32'(int_n_o), 32'h1);
    check("R1 rdata after reset", 32'(host_rdata_o), 32'h0);
    host_read(0, 8'h18, d); check("R1 mask reset", 32'(d), 32'h0);
    host_read(1, 8'h11, d); check("R1 status reset", 32'(d), 32'h0);
    host_read(3, 8'h0C, d); check("R1 summary reset", 32'(d), 32'h0);
  endtask

  task automatic t_level;
    logic [7:0] d;
    set_evt(ev(0, 0, 0), 1'b1);
    host_read(0, 8'h10, d); check("R2 level first read", 32'(d), 32'h01);
    host_read(0, 8'h10, d); check("R2 level survives read", 32'(d), 32'h01);
    set_evt(ev(0, 0, 0), 1'b0);
    host_read(0, 8'h10, d); check("R2 latched after drop", 32'(d), 32'h01);
    host_read(0, 8'h10, d); check("R2 cleared by read", 32'(d), 32'h00);
  endtask

  task automatic t_oneshot;
    logic [7:0] d;
    set_evt(ev(1, 1, 5), 1'b1);
    host_read(1, 8'h11, d); check("R3 edge fires", 32'(d), 32'h20);
    host_read(1, 8'h11, d); check("R3 no refire while held", 32'(d), 32'h00);
    set_evt(ev(1, 1, 5), 1'b0);
    repeat (2) @(negedge clk);
    host_read(1, 8'h11, d); check("R3 quiet after drop", 32'(d), 32'h00);
    set_evt(ev(1, 1, 5), 1'b1);
    host_read(1, 8'h11, d); check("R3 rearmed fire", 32'(d), 32'h20);
    set_evt(ev(1, 1, 5), 1'b0);
  endtask

  task automatic t_mask_int;
    logic [7:0] d;
    set_evt(ev(2, 0, 1), 1'b1);
    repeat (3) @(negedge clk);
    check("R5 masked source keeps int_n high", 32'(int_n_o), 32'h1);
    host_read(0, 8'h0C, d); check("R5 masked source not in summary", 32'(d), 32'h0);
    host_read(2, 8'h10, d); check("R5 masked bit still latches", 32'(d), 32'h02);
    host_write(2, 8'h18, 8'h02);
    check("R7 int_n one cycle late", 32'(int_n_o), 32'h1);
    @(negedge clk);
    check("R7 int_n asserted", 32'(int_n_o), 32'h0);
    host_read(2, 8'h18, d); check("R5 mask readback", 32'(d), 32'h02);
    host_read(0, 8'h0C, d); check("R6 summary port0 0x0C", 32'(d), 32'h10);
    host_read(3, 8'h0D, d); check("R6 summary port3 0x0D", 32'(d), 32'h10);
    host_read(1, 8'h0E, d); check("R6 summary port1 0x0E", 32'(d), 32'h10);
    set_evt(ev(2, 0, 1), 1'b0);
    host_read(2, 8'h10, d); check("R4 clearing read value", 32'(d), 32'h02);
    check("R7 int_n still low after clear edge", 32'(int_n_o), 32'h0);
    @(negedge clk);
    check("R7 int_n released", 32'(int_n_o), 32'h1);
  endtask

  task automatic t_isolation;
    logic [7:0] d;
    @(negedge clk);
    evt_i[ev(3, 0, 4)] = 1'b1;
    evt_i[ev(3, 1, 6)] = 1'b1;
    @(negedge clk);
    evt_i[ev(3, 0, 4)] = 1'b0;
    evt_i[ev(3, 1, 6)] = 1'b0;
    host_read(0, 8'h10, d); check("R4 other port empty", 32'(d), 32'h00);
    host_read(3, 8'h10, d); check("R4 reg0 value", 32'(d), 32'h10);
    host_read(3, 8'h10, d); check("R4 reg0 cleared", 32'(d), 32'h00);
    host_read(3, 8'h11, d); check("R4 reg1 untouched", 32'(d), 32'h40);
    host_read(3, 8'h11, d); check("R4 reg1 cleared", 32'(d), 32'h00);
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    host_write(1, 8'h10, 8'hFF);
    host_write(1, 8'h0C, 8'hFF);
    host_read(1, 8'h10, d); check("R8 status write ignored", 32'(d), 32'h00);
    host_read(1, 8'h18, d); check("R8 mask untouched", 32'(d), 32'h00);
    host_read(1, 8'h0C, d); check("R8 summary write ignored", 32'(d), 32'h00);
    host_read(2, 8'h05, d); check("R8 unmapped reads zero", 32'(d), 32'h00);
    check("R8 int_n unaffected", 32'(int_n_o), 32'h1);
  endtask

  task automatic t_kinds;
    logic [7:0] d;
    @(negedge clk);
    evt_i[ev(0, 1, 3)] = 1'b1;
    evt_i[ev(0, 1, 4)] = 1'b1;
    host_read(0, 8'h11, d); check("R9 both kinds set", 32'(d), 32'h18);
    host_read(0, 8'h11, d); check("R9 only level survives", 32'(d), 32'h08);
    @(negedge clk);
    evt_i[ev(0, 1, 3)] = 1'b0;
    evt_i[ev(0, 1, 4)] = 1'b0;
    host_read(0, 8'h11, d); check("R9 level latched", 32'(d), 32'h08);
    host_read(0, 8'h11, d); check("R9 all clear", 32'(d), 32'h00);
  endtask

  task automatic t_summary_multi;
    logic [7:0] d;
    host_write(0, 8'h18, 8'hFF);
    host_write(3, 8'h19, 8'hFF);
    @(negedge clk);
    evt_i[ev(0, 0, 0)] = 1'b1;
    evt_i[ev(3, 1, 0)] = 1'b1;
    host_read(2, 8'h0D, d); check("R6 summary corner bits", 32'(d), 32'h81);
    @(negedge clk);
    check("R7 int_n low with two sources", 32'(int_n_o), 32'h0);
    @(negedge clk);
    evt_i[ev(0, 0, 0)] = 1'b0;
    evt_i[ev(3, 1, 0)] = 1'b0;
    host_read(0, 8'h10, d);
    host_read(3, 8'h11, d);
    repeat (2) @(negedge clk);
    host_read(1, 8'h0E, d); check("R6 summary empty", 32'(d), 32'h00);
    check("R7 int_n idle again", 32'(int_n_o), 32'h1);
  endtask

  initial begin
    rst_i        = 1'b1;
    evt_i        = '0;
    host_sel_i   = '0;
    host_addr_i  = '0;
    host_wr_i    = 1'b0;
    host_wdata_i = '0;
    host_rd_i    = 1'b0;
    repeat (4) @(negedge clk);
    rst_i = 1'b0;
    @(negedge clk);
    t_reset();
    t_level();
    t_oneshot();
    t_mask_int();
    t_isolation();
    t_ignored();
    t_kinds();
    t_summary_multi();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule